// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Switch

This block chooses the clock that drives a small processor core and its peripherals. After power-on reset or a wake from sleep, a crystal oscillator needs time to settle. The block starts the core on the internal oscillator at once. Meanwhile a start-up timer in the external clock domain counts crystal cycles. When the count is done, the block hands the core over to the external clock. The switch is glitch-free: the old clock is cut on its own falling edge, the system clock is held low, and the new clock is let through on its own falling edge.

A software select bit can force the internal oscillator at any time. The state machine's own switches never change that bit. A status flag tells software whether the external source chosen by the mode field is driving the core. A sleep request stops the system clock. A wake event restarts the whole start-up sequence, including a fresh timer count. When the internal/external enable is off, a crystal start-up keeps the system clock gated low until the timer completes. Sources that need no settling skip the timer entirely.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: While `sel_q` is 1 the internal clock drives `sys_clk` and `src_ext` is 0. `sel_q` is loaded from `sel_wd` on a rising `clk_int` edge with `sel_we` high.
- R2: `rst` is synchronous to `clk_int` and active high. It clears `sel_q` and `src_ext`, and holds `sys_clk` low.
- R3: `osc_mode` encoding: 0, 1 and 2 are crystal modes, 3 is a ready external clock, and 4 to 7 select the internal oscillator, with `src_ext` left at 0.
- R4: With `dual_en`=1, `sel_q`=0 and a crystal mode, `sys_clk` follows `clk_int` within 16 `clk_int` cycles of reset release or wake, while the timer counts.
- R5: The timer counts 1024 rising `clk_ext` edges and restarts from zero at every start-up. `src_ext` stays 0 until the count completes.
- R6: After the count, `src_ext` rises on a `clk_int` falling edge. `sys_clk` is then held low until a `clk_ext` falling edge, after which it follows `clk_ext`.
- R7: Automatic switches never alter `sel_q`. Only a write changes it.
- R8: A `sleep_req` pulse holds `sys_clk` low and clears `src_ext` within 16 `clk_int` cycles. A sleep during the count abandons the count.
- R9: In a crystal mode with `dual_en`=0 and `sel_q`=0, `sys_clk` stays low for the whole count and then follows `clk_ext`.
- R10: In mode 3 with `sel_q`=0, `sys_clk` follows `clk_ext` with `src_ext`=1 within 20 `clk_int` cycles of start-up, with no count.
- R11: No high or low phase of `sys_clk` is shorter than the shorter half period of the two clocks. At most one clock branch is enabled at a time.
- R12: `src_ext` rises exactly once for each handover to the mode's external source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Internal oscillator clock; control domain |
| clk_ext | input | 1 | External oscillator clock |
| rst | input | 1 | Synchronous active-high reset (clk_int) |
| wake | input | 1 | Wake event pulse, honoured while asleep |
| sleep_req | input | 1 | Sleep request pulse |
| sel_we | input | 1 | Write strobe for the software select bit |
| sel_wd | input | 1 | Value written to the software select bit |
| dual_en | input | 1 | Enables running on the internal clock during the count |
| osc_mode | input | 3 | Oscillator mode field |
| sys_clk | output | 1 | Glitch-free system clock |
| src_ext | output | 1 | High while the mode's external source drives the core |
| sel_q | output | 1 | Current software select bit |

## Verification
Timing is set by the synchronisers, so each result has a due window rather than a single cycle. The internal clock must appear within 10 `clk_int` cycles of reset release or a wake. Sleep, select writes and bypass starts settle within 16 to 20 cycles. The handover is due about 1800 `clk_int` cycles after start-up (1024 `clk_ext` periods plus synchroniser stages). The behavioural reference model compares `sys_clk` and `src_ext` on every clock. It is switched off during each transition window and switched back on only after that window closes. It still checks that the previous source holds until roughly 37 external periods before the earliest completion of a count that restarted from zero.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_START,
        ST_CNT_INT,
        ST_CNT_OFF,
        ST_RUN_EXT,
        ST_RUN_INT,
        ST_SLEEP
    } tsc_state_e;

    typedef enum logic [1:0] {
        SRC_XTAL,
        SRC_EXTCLK,
        SRC_INTOSC
    } src_kind_e;

    typedef struct packed {
        logic want_int;
        logic want_ext;
        logic count_run;
    } clk_req_t;

    function automatic src_kind_e decode_mode(input logic [MODE_W-1:0] m);
        if (m < MODE_W'(3))       return SRC_XTAL;
        else if (m == MODE_W'(3)) return SRC_EXTCLK;
        else                      return SRC_INTOSC;
    endfunction

endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync #(
    parameter int STAGES   = 2,
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (NEG_EDGE) begin : g_neg
            always_ff @(negedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_pos
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tsc_timer.sv
`timescale 1ns/1ps
module tsc_timer #(
    parameter int COUNT  = 1024,
    parameter int STAGES = 2
) (
    input  logic clk_ext,
    input  logic rst_ext,
    input  logic run_a,
    output logic done
);
    localparam int CW = $clog2(COUNT + 1);

    logic          run_s;
    logic [CW-1:0] cnt;

    tsc_sync #(.STAGES(STAGES), .NEG_EDGE(1'b0)) u_run (
        .clk(clk_ext), .rst(rst_ext), .d(run_a), .q(run_s)
    );

    always_ff @(posedge clk_ext) begin
        if (rst_ext || !run_s) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(COUNT - 1)) done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tsc_clkmux.sv
`timescale 1ns/1ps
module tsc_clkmux #(
    parameter int STAGES = 2
) (
    input  logic clk_int,
    input  logic clk_ext,
    input  logic rst,
    input  logic rst_ext,
    input  logic want_int,
    input  logic want_ext,
    output logic int_on,
    output logic ext_on,
    output logic ext_ack,
    output logic sys_clk
);
    logic ext_on_n;
    logic int_on_n;
    logic want_ext_s;

    // internal branch: gated on clk_int falling edges only
    tsc_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1)) u_ext_seen (
        .clk(clk_int), .rst(rst), .d(ext_on), .q(ext_on_n)
    );

    always_ff @(negedge clk_int) begin
        if (rst) int_on <= 1'b0;
        else     int_on <= want_int && !ext_on_n;
    end

    // external branch: gated on clk_ext falling edges only
    tsc_sync #(.STAGES(STAGES), .NEG_EDGE(1'b0)) u_want_ext (
        .clk(clk_ext), .rst(rst_ext), .d(want_ext), .q(want_ext_s)
    );
    tsc_sync #(.STAGES(STAGES), .NEG_EDGE(1'b1)) u_int_seen (
        .clk(clk_ext), .rst(rst_ext), .d(int_on), .q(int_on_n)
    );

    always_ff @(negedge clk_ext) begin
        if (rst_ext) ext_on <= 1'b0;
        else         ext_on <= want_ext_s && !int_on_n;
    end

    assign ext_ack = want_ext_s;
    assign sys_clk = (clk_int & int_on) | (clk_ext & ext_on);
endmodule

// File: rtl/tsc_ctrl.sv
`timescale 1ns/1ps
module tsc_ctrl
    import tsc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk_int,
    input  logic              rst,
    input  logic              wake,
    input  logic              sleep_req,
    input  logic              sel_we,
    input  logic              sel_wd,
    input  logic              dual_en,
    input  logic [MODE_W-1:0] osc_mode,
    input  logic              done_a,
    input  logic              int_on,
    input  logic              ext_on_a,
    input  logic              ext_ack_a,
    output clk_req_t          req,
    output logic              sel_q,
    output logic              src_ext
);
    localparam int NSYNC = 3;

    tsc_state_e       state, nxt;
    src_kind_e        kind;
    logic [NSYNC-1:0] raw, synced;
    logic             done_s, ext_on_s, ext_ack_s;
    logic             osc_ok, sleep_p, wake_p, settled;

    assign raw = {done_a, ext_on_a, ext_ack_a};

    for (genvar i = 0; i < NSYNC; i++) begin : g_sync
        tsc_sync #(.STAGES(STAGES), .NEG_EDGE(1'b0)) u_s (
            .clk(clk_int), .rst(rst), .d(raw[i]), .q(synced[i])
        );
    end

    assign {done_s, ext_on_s, ext_ack_s} = synced;
    assign kind = decode_mode(osc_mode);

    always_comb begin
        req.want_int  = (state == ST_CNT_INT) || (state == ST_RUN_INT);
        req.want_ext  = (state == ST_RUN_EXT);
        req.count_run = (state == ST_CNT_INT) || (state == ST_CNT_OFF);
    end

    // one switch in flight at a time: move only when both branches match the request
    assign settled = (int_on == req.want_int) && (ext_on_s == req.want_ext) &&
                     (ext_ack_s == req.want_ext);

    always_comb begin
        nxt = state;
        if (settled) begin
            case (state)
                ST_START: begin
                    if (sleep_p)                             nxt = ST_SLEEP;
                    else if (sel_q || kind == SRC_INTOSC)    nxt = ST_RUN_INT;
                    else if (kind == SRC_EXTCLK || osc_ok)   nxt = ST_RUN_EXT;
                    else if (!done_s)                        nxt = dual_en ? ST_CNT_INT : ST_CNT_OFF;
                end
                ST_CNT_INT, ST_CNT_OFF: begin
                    if (sleep_p)      nxt = ST_SLEEP;
                    else if (sel_q)   nxt = ST_RUN_INT;
                    else if (done_s)  nxt = ST_RUN_EXT;
                end
                ST_RUN_EXT: begin
                    if (sleep_p)      nxt = ST_SLEEP;
                    else if (sel_q)   nxt = ST_RUN_INT;
                end
                ST_RUN_INT: begin
                    if (sleep_p)                              nxt = ST_SLEEP;
                    else if (!sel_q && kind != SRC_INTOSC)    nxt = ST_START;
                end
                ST_SLEEP: begin
                    if (wake || wake_p) nxt = ST_START;
                end
                default: nxt = ST_START;
            endcase
        end
    end

    always_ff @(posedge clk_int) begin
        if (rst) begin
            state   <= ST_START;
            sel_q   <= 1'b0;
            osc_ok  <= 1'b0;
            sleep_p <= 1'b0;
            wake_p  <= 1'b0;
        end else begin
            state <= nxt;
            if (sel_we) sel_q <= sel_wd;

            if (state == ST_SLEEP)
                osc_ok <= 1'b0;
            else if (req.count_run && nxt == ST_RUN_EXT)
                osc_ok <= 1'b1;

            if (state == ST_SLEEP)  sleep_p <= 1'b0;
            else if (sleep_req)     sleep_p <= 1'b1;

            if (state != ST_SLEEP)  wake_p <= 1'b0;
            else if (wake)          wake_p <= 1'b1;
        end
    end

    // flag follows the handover on the internal clock's falling edge
    always_ff @(negedge clk_int) begin
        if (rst) src_ext <= 1'b0;
        else     src_ext <= (state == ST_RUN_EXT);
    end
endmodule

// File: rtl/twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module twospeed_clk_ctrl
    import tsc_pkg::*;
#(
    parameter int START_COUNT = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_int,
    input  logic              clk_ext,
    input  logic              rst,
    input  logic              wake,
    input  logic              sleep_req,
    input  logic              sel_we,
    input  logic              sel_wd,
    input  logic              dual_en,
    input  logic [MODE_W-1:0] osc_mode,
    output logic              sys_clk,
    output logic              src_ext,
    output logic              sel_q
);
    clk_req_t req;
    logic     rst_ext;
    logic     done;
    logic     int_on;
    logic     ext_on;
    logic     ext_ack;

    tsc_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0)) u_rst_ext (
        .clk(clk_ext), .rst(1'b0), .d(rst), .q(rst_ext)
    );

    tsc_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
        .clk_int   (clk_int),
        .rst       (rst),
        .wake      (wake),
        .sleep_req (sleep_req),
        .sel_we    (sel_we),
        .sel_wd    (sel_wd),
        .dual_en   (dual_en),
        .osc_mode  (osc_mode),
        .done_a    (done),
        .int_on    (int_on),
        .ext_on_a  (ext_on),
        .ext_ack_a (ext_ack),
        .req       (req),
        .sel_q     (sel_q),
        .src_ext   (src_ext)
    );

    tsc_timer #(.COUNT(START_COUNT), .STAGES(SYNC_STAGES)) u_timer (
        .clk_ext (clk_ext),
        .rst_ext (rst_ext),
        .run_a   (req.count_run),
        .done    (done)
    );

    tsc_clkmux #(.STAGES(SYNC_STAGES)) u_mux (
        .clk_int  (clk_int),
        .clk_ext  (clk_ext),
        .rst      (rst),
        .rst_ext  (rst_ext),
        .want_int (req.want_int),
        .want_ext (req.want_ext),
        .int_on   (int_on),
        .ext_on   (ext_on),
        .ext_ack  (ext_ack),
        .sys_clk  (sys_clk)
    );
endmodule

// File: rtl/tsc_checker.sv
`timescale 1ns/1ps
module tsc_checker (
    input logic clk_int,
    input logic rst,
    input logic sel_we,
    input logic sel_q,
    input logic src_ext,
    input logic int_on,
    input logic ext_on
);
    a_r2_reset_clears: assert property (@(posedge clk_int) disable iff (rst)
        $fell(rst) |-> (!src_ext && !sel_q));

    a_r7_sel_write_only: assert property (@(posedge clk_int) disable iff (rst)
        !sel_we |=> $stable(sel_q));

    a_r11_one_branch: assert property (@(posedge clk_int) disable iff (rst)
        $onehot0({int_on, ext_on}));

    a_r1_no_ext_when_forced: assert property (@(posedge clk_int) disable iff (rst)
        $rose(src_ext) |-> !$past(sel_q));
endmodule

bind twospeed_clk_ctrl tsc_checker u_chk (
    .clk_int (clk_int),
    .rst     (rst),
    .sel_we  (sel_we),
    .sel_q   (sel_q),
    .src_ext (src_ext),
    .int_on  (int_on),
    .ext_on  (ext_on)
);

// File: tb/sim_twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module sim_twospeed_clk_ctrl;
    logic       clk_int = 1'b0;
    logic       clk_ext = 1'b0;
    logic       rst = 1'b1;
    logic       wake = 1'b0;
    logic       sleep_req = 1'b0;
    logic       sel_we = 1'b0;
    logic       sel_wd = 1'b0;
    logic       dual_en = 1'b1;
    logic [2:0] osc_mode = 3'd1;
    logic       sys_clk, src_ext, sel_q;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk_int = ~clk_int;               // 125 MHz
    initial begin
        #1.3;
        forever #7 clk_ext = ~clk_ext;           // unrelated, slower
    end

    twospeed_clk_ctrl u0 (
        .clk_int(clk_int), .clk_ext(clk_ext), .rst(rst), .wake(wake),
        .sleep_req(sleep_req), .sel_we(sel_we), .sel_wd(sel_wd),
        .dual_en(dual_en), .osc_mode(osc_mode),
        .sys_clk(sys_clk), .src_ext(src_ext), .sel_q(sel_q)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
        end
    endtask

    // behavioural reference: expected source and flag, compared every clock
    typedef enum {M_OFF, M_INT, M_EXT} msrc_e;
    msrc_e exp_src = M_OFF;
    logic  exp_flag = 1'b0;
    bit    model_on = 1'b0;
    int    win_bad = 0;
    string win_act = "";
    logic  ref_clk;

    always @(posedge clk_int) begin
        #2;
        if (model_on) begin
            ref_clk = (exp_src == M_INT) ? clk_int : (exp_src == M_EXT) ? clk_ext : 1'b0;
            if (sys_clk !== ref_clk || src_ext !== exp_flag) begin
                if (win_bad == 0)
                    win_act = $sformatf("sys=%b flag=%b (ref sys=%b)", sys_clk, src_ext, ref_clk);
                win_bad++;
            end
        end
    end

    // phase-width and flag-rise monitors
    bit      mon_on = 1'b0;
    realtime t_last = 0.0;
    int      n_short = 0;
    int      n_rise = 0;

    always @(sys_clk) begin
        if (mon_on && ($realtime - t_last) < 3.9) n_short++;
        t_last = $realtime;
    end
    always @(posedge src_ext) if (mon_on) n_rise++;

    task automatic cyc(input int n);
        repeat (n) @(posedge clk_int);
    endtask

    task automatic window(input msrc_e s, input logic f, input string req,
                          input int settle, input int len);
        model_on = 1'b0;
        cyc(settle);
        exp_src = s; exp_flag = f; win_bad = 0; win_act = "";
        model_on = 1'b1;
        cyc(len);
        model_on = 1'b0;
        chk(win_bad == 0, req, $sformatf("source %s window", s.name()), win_act,
            $sformatf("%s flag=%b", s.name(), f));
    endtask

    task automatic do_sleep;
        @(posedge clk_int); #1 sleep_req = 1'b1;
        @(posedge clk_int); #1 sleep_req = 1'b0;
        window(M_OFF, 1'b0, "R8", 16, 40);
    endtask

    task automatic do_wake;
        @(posedge clk_int); #1 wake = 1'b1;
        @(posedge clk_int); #1 wake = 1'b0;
    endtask

    task automatic write_sel(input logic v);
        @(posedge clk_int); #1 sel_we = 1'b1; sel_wd = v;
        @(posedge clk_int); #1 sel_we = 1'b0;
    endtask

    // crystal start-up: first source until ~989 ext periods, external by ~1085
    task automatic xtal_startup(input msrc_e first, input string req);
        window(first, 1'b0, req, 10, 1720);
        window(M_EXT, 1'b1, "R6", 170, 100);
    endtask

    initial begin
        cyc(8);
        #2;
        chk(sys_clk === 1'b0 && src_ext === 1'b0 && sel_q === 1'b0, "R2", "reset state",
            $sformatf("%b%b%b", sys_clk, src_ext, sel_q), "000");
        @(posedge clk_int); #1 rst = 1'b0;
        t_last = $realtime; mon_on = 1'b1;

        // two-speed start-up after reset
        xtal_startup(M_INT, "R4 R5");
        chk(sel_q === 1'b0, "R7", "select after auto switch", $sformatf("%b", sel_q), "0");

        // sleep, wake, abort the count by sleeping again
        do_sleep();
        do_wake();
        window(M_INT, 1'b0, "R4", 10, 290);
        do_sleep();

        // wake again: count must restart from zero
        do_wake();
        xtal_startup(M_INT, "R5 restart");

        // crystal without two-speed: clock gated through the count
        do_sleep();
        dual_en = 1'b0;
        do_wake();
        xtal_startup(M_OFF, "R9");

        // software select forces internal, then releases
        write_sel(1'b1);
        window(M_INT, 1'b0, "R1", 20, 60);
        chk(sel_q === 1'b1, "R1", "select readback", $sformatf("%b", sel_q), "1");
        write_sel(1'b0);
        window(M_EXT, 1'b1, "R1", 20, 60);

        // external clock mode: no count
        do_sleep();
        osc_mode = 3'd3; dual_en = 1'b1;
        do_wake();
        window(M_EXT, 1'b1, "R10", 20, 60);

        // internal oscillator mode
        do_sleep();
        osc_mode = 3'd5;
        do_wake();
        window(M_INT, 1'b0, "R3", 20, 60);

        // select written while asleep takes effect on wake
        do_sleep();
        osc_mode = 3'd1;
        write_sel(1'b1);
        do_wake();
        window(M_INT, 1'b0, "R1", 20, 60);

        // reset clears the select bit and restarts two-speed start-up
        @(posedge clk_int); #1 rst = 1'b1;
        cyc(4); #2;
        chk(sys_clk === 1'b0 && src_ext === 1'b0 && sel_q === 1'b0, "R2", "reset clears",
            $sformatf("%b%b%b", sys_clk, src_ext, sel_q), "000");
        @(posedge clk_int); #1 rst = 1'b0;
        xtal_startup(M_INT, "R4");

        chk(n_rise == 6, "R12", "flag rises", $sformatf("%0d", n_rise), "6");
        chk(n_short == 0, "R11", "short phases", $sformatf("%0d", n_short), "0");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule